// File: doc/BRIEF.md
# Displacement and Immediate Byte Gatherer

This unit sits behind an instruction decoder. Once the decoder knows how many displacement bytes and how many operand bytes an instruction carries, it loads those two lengths into the gatherer. The gatherer then collects exactly that many bytes from a byte stream. The stream may deliver the bytes in bursts with idle cycles between them. The gatherer treats the bytes as little-endian fields, with the displacement field first and the operand field after it.

While it is still collecting, the unit reports how many bytes it still needs. When the final byte arrives, it raises a one-cycle completion pulse and presents a 16-bit signed displacement and a 16-bit operand. Both values stay on the outputs until the next completion.

An 8-bit immediate that feeds a word-sized operation is sign-extended. Port-access instructions are the exception: their 8-bit immediate is zero-extended. A far-pointer operand code makes the unit take four bytes: the first two bytes form an offset and the next two form a segment.

Top module: `disp_imm_gather`

## Requirements
- R1: After reset, `busy_o`=0, `done_o`=0, `remaining_o`=0, and `disp_o`=`opnd_o`=0.
- R2: `start_i` in a cycle with `busy_o`=0 loads the lengths. From the next cycle, `remaining_o` equals the displacement byte count plus the operand byte count. Displacement codes: `disp_len_i` 0 = none, 1 = one byte, 2 or 3 = two bytes. Operand codes: `opnd_len_i` 0 = none, 1 = one byte, 2 = two bytes, 3 = far pointer of four bytes. While the unit is idle, `remaining_o` is 0.
- R3: Each cycle with `busy_o`=1 and `byte_valid_i`=1 consumes one byte, and `remaining_o` falls by one on the following edge. A cycle without `byte_valid_i` leaves `remaining_o` unchanged.
- R4: The edge that takes the last needed byte sets `done_o` for exactly one cycle. On that same edge, `busy_o` goes to 0 and `remaining_o` goes to 0. No completion happens before that edge.
- R5: A start with both lengths zero sets `done_o` on the very next edge, with `disp_o`=0 and `opnd_o`=0.
- R6: Displacement bytes arrive first, least significant byte first. A one-byte displacement is sign-extended from bit 7. A two-byte displacement is taken as is. With no displacement, `disp_o` is 0.
- R7: Operand bytes follow the displacement, least significant byte first. A two-byte operand is taken as is. With no operand, `opnd_o` is 0.
- R8: A one-byte operand is sign-extended from bit 7 only when `word_op_i`=1 and `port_io_i`=0. Otherwise it is zero-extended.
- R9: With operand code 3, `disp_len_i` is ignored and four bytes are taken. `disp_o` is built from bytes 0 and 1, and `opnd_o` from bytes 2 and 3, each least significant byte first.
- R10: `start_i` while `busy_o`=1 is ignored. `byte_valid_i` while `busy_o`=0 is ignored.
- R11: `disp_o` and `opnd_o` change only on the edge that sets `done_o`, and they hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load new lengths (taken only when idle) |
| disp_len_i | input | 2 | Displacement length code |
| opnd_len_i | input | 2 | Operand length code |
| word_op_i | input | 1 | Operation works on 16-bit data |
| port_io_i | input | 1 | Operation is a port access (no sign extension) |
| byte_valid_i | input | 1 | Stream byte present |
| byte_i | input | 8 | Stream byte |
| busy_o | output | 1 | Collection in progress |
| remaining_o | output | 3 | Bytes still needed |
| done_o | output | 1 | One-cycle completion pulse |
| disp_o | output | 16 | Signed displacement |
| opnd_o | output | 16 | Operand value |

## Verification
The assertions check the following on every cycle:
- the count-down of `remaining_o` on each accepted byte and its stability across stream gaps;
- the one-cycle shape of the completion pulse, and that `busy_o` and `remaining_o` are clear while it is high;
- that starts arriving mid-collection are ignored, and that the count is zero while idle;
- that the result outputs hold between completions.

Only the bench scenarios can show that the assembled values are right. These scenarios cover field order and byte order, sign extension versus zero extension under the word and port-access inputs, the far-pointer split, the length code 3 for a two-byte displacement, and that stream bytes offered while idle leave the outputs untouched.

// File: rtl/gather_pkg.sv
`timescale 1ns/1ps
package gather_pkg;
  typedef enum logic [1:0] {
    OPND_NONE = 2'd0,
    OPND_BYTE = 2'd1,
    OPND_WORD = 2'd2,
    OPND_FAR  = 2'd3
  } opnd_code_e;

  // normalized byte counts; far pointer is folded into 2 + 2
  typedef struct packed {
    logic [1:0] disp_n;
    logic [1:0] opnd_n;
    logic       sext;
  } gather_cfg_t;

  function automatic gather_cfg_t norm_cfg(input logic [1:0] disp_code,
                                           input logic [1:0] opnd_code,
                                           input logic       word_op,
                                           input logic       port_op);
    gather_cfg_t c;
    c.sext = word_op & ~port_op;
    if (opnd_code == OPND_FAR) begin
      c.disp_n = 2'd2;
      c.opnd_n = 2'd2;
    end else begin
      c.disp_n = (disp_code == 2'd0) ? 2'd0 : (disp_code == 2'd1) ? 2'd1 : 2'd2;
      c.opnd_n = opnd_code;
    end
    return c;
  endfunction
endpackage

// File: rtl/gather_ctrl.sv
`timescale 1ns/1ps
module gather_ctrl #(
  parameter int CNT_W = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             byte_valid_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] slot_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             load_o,
  output logic             take_o,
  output logic             last_o,
  output logic             empty_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] need_q, cnt_q;

  assign load_o  = start_i & ~busy_q;
  assign empty_o = load_o & (total_i == '0);
  assign take_o  = busy_q & byte_valid_i;
  assign last_o  = take_o & (cnt_q == need_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      need_q <= '0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= ~empty_o;
      done_q <= empty_o;
      need_q <= total_i;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (take_o) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign slot_o      = cnt_q[IDX_W-1:0];
  assign remaining_o = busy_q ? (need_q - cnt_q) : '0;
endmodule

// File: rtl/gather_lanes.sv
`timescale 1ns/1ps
module gather_lanes #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             slot_i,
  input  logic [BYTE_W-1:0]            byte_i,
  output logic [LANES-1:0][BYTE_W-1:0] view_o
);
  // view_o already contains the byte being written this cycle
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              hit;
    assign hit = wr_i & (slot_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lane_q <= '0;
      else if (hit) lane_q <= byte_i;
    end
    assign view_o[g] = hit ? byte_i : lane_q;
  end
endmodule

// File: rtl/gather_former.sv
`timescale 1ns/1ps
module gather_former
  import gather_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int IDX_W  = 2,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic [LANES-1:0][BYTE_W-1:0] lanes_i,
  input  gather_cfg_t                  cfg_i,
  output logic [DATA_W-1:0]            disp_o,
  output logic [DATA_W-1:0]            opnd_o
);
  logic [IDX_W-1:0]  lo_idx, hi_idx;
  logic [BYTE_W-1:0] op_lo, op_hi;

  assign lo_idx = IDX_W'(cfg_i.disp_n);
  assign hi_idx = lo_idx + IDX_W'(1);
  assign op_lo  = lanes_i[lo_idx];
  assign op_hi  = lanes_i[hi_idx];

  always_comb begin
    unique case (cfg_i.disp_n)
      2'd0:    disp_o = '0;
      2'd1:    disp_o = {{BYTE_W{lanes_i[0][BYTE_W-1]}}, lanes_i[0]};
      default: disp_o = {lanes_i[1], lanes_i[0]};
    endcase
  end

  always_comb begin
    unique case (cfg_i.opnd_n)
      2'd0:    opnd_o = '0;
      2'd1:    opnd_o = {{BYTE_W{cfg_i.sext & op_lo[BYTE_W-1]}}, op_lo};
      default: opnd_o = {op_hi, op_lo};
    endcase
  end
endmodule

// File: rtl/disp_imm_gather.sv
`timescale 1ns/1ps
module disp_imm_gather
  import gather_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        disp_len_i,
  input  logic [1:0]        opnd_len_i,
  input  logic              word_op_i,
  input  logic              port_io_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  remaining_o,
  output logic              done_o,
  output logic [DATA_W-1:0] disp_o,
  output logic [DATA_W-1:0] opnd_o
);
  gather_cfg_t              cfg_d, cfg_q;
  logic [CNT_W-1:0]         total;
  logic [IDX_W-1:0]         slot;
  logic                     load, take, last, empty;
  logic [LANES-1:0][BYTE_W-1:0] view;
  logic [DATA_W-1:0]        disp_d, opnd_d, disp_q, opnd_q;

  assign cfg_d = norm_cfg(disp_len_i, opnd_len_i, word_op_i, port_io_i);
  assign total = CNT_W'(cfg_d.disp_n) + CNT_W'(cfg_d.opnd_n);

  gather_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .total_i     (total),
    .byte_valid_i(byte_valid_i),
    .busy_o      (busy_o),
    .slot_o      (slot),
    .remaining_o (remaining_o),
    .load_o      (load),
    .take_o      (take),
    .last_o      (last),
    .empty_o     (empty),
    .done_o      (done_o)
  );

  gather_lanes #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) i_lanes (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (take),
    .slot_i(slot),
    .byte_i(byte_i),
    .view_o(view)
  );

  gather_former #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) i_former (
    .lanes_i(view),
    .cfg_i  (cfg_q),
    .disp_o (disp_d),
    .opnd_o (opnd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      disp_q <= '0;
      opnd_q <= '0;
    end else begin
      if (load) cfg_q <= cfg_d;
      if (empty) begin
        disp_q <= '0;
        opnd_q <= '0;
      end else if (last) begin
        disp_q <= disp_d;
        opnd_q <= opnd_d;
      end
    end
  end

  assign disp_o = disp_q;
  assign opnd_o = opnd_q;
endmodule

// File: rtl/disp_imm_gather_chk.sv
`timescale 1ns/1ps
module disp_imm_gather_chk #(
  parameter int CNT_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              byte_valid_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  remaining_o,
  input logic              done_o,
  input logic [DATA_W-1:0] disp_o,
  input logic [DATA_W-1:0] opnd_o
);
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> remaining_o == '0);

  assert_start_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o || done_o);

  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && byte_valid_i && remaining_o > CNT_W'(1) |=>
      busy_o && remaining_o == $past(remaining_o) - CNT_W'(1));

  assert_gap_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !byte_valid_i |=> busy_o && $stable(remaining_o));

  assert_last_byte_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && byte_valid_i && remaining_o == CNT_W'(1) |=> done_o);

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && remaining_o == '0);

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !byte_valid_i |=> busy_o && $stable(remaining_o));

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(disp_o) && $stable(opnd_o));
endmodule

bind disp_imm_gather disp_imm_gather_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .byte_valid_i(byte_valid_i),
  .busy_o      (busy_o),
  .remaining_o (remaining_o),
  .done_o      (done_o),
  .disp_o      (disp_o),
  .opnd_o      (opnd_o)
);

// File: tb/test_disp_imm_gather.sv
`timescale 1ns/1ps
module test_disp_imm_gather;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  disp_len = '0, opnd_len = '0;
  logic        word_op = 1'b0, port_io = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        busy, done;
  logic [2:0]  remaining;
  logic [15:0] disp, opnd;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [31:0] last_exp = '0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  disp_imm_gather i_disp_imm_gather (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .disp_len_i(disp_len),
    .opnd_len_i(opnd_len), .word_op_i(word_op), .port_io_i(port_io),
    .byte_valid_i(byte_valid), .byte_i(byte_in), .busy_o(busy),
    .remaining_o(remaining), .done_o(done), .disp_o(disp), .opnd_o(opnd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] dl, input logic [1:0] ol,
                                        input logic w, input logic p, input logic [31:0] by);
    int dn, on;
    logic [7:0] b0, b1, o0, o1;
    logic [15:0] d, o;
    dn = (ol == 2'd3) ? 2 : (dl == 2'd0) ? 0 : (dl == 2'd1) ? 1 : 2;
    on = (ol == 2'd3) ? 2 : int'(ol);
    b0 = by[7:0];
    b1 = by[15:8];
    o0 = by[8*dn +: 8];
    o1 = by[8*(dn+1) +: 8];
    d = (dn == 0) ? 16'h0 : (dn == 1) ? {{8{b0[7]}}, b0} : {b1, b0};
    if (on == 0)      o = 16'h0;
    else if (on == 1) o = (w && !p) ? {{8{o0[7]}}, o0} : {8'h00, o0};
    else              o = {o1, o0};
    return {d, o};
  endfunction

  // monitor: pops the scoreboard on each completion pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {disp, opnd}, e.val);
      end
    end
  end

  task automatic xfer(input string tag, input logic [1:0] dl, input logic [1:0] ol,
                      input logic w, input logic p, input logic [31:0] by,
                      input int gap, input bit poke);
    int n;
    exp_t e;
    n = (ol == 2'd3) ? 4 : ((dl == 2'd0) ? 0 : (dl == 2'd1) ? 1 : 2) + int'(ol);
    e.val = model(dl, ol, w, p, by);
    e.tag = tag;
    @(negedge clk);
    exp_q.push_back(e);
    last_exp = e.val;
    start = 1'b1; disp_len = dl; opnd_len = ol; word_op = w; port_io = p;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check("R5 empty start done", {31'd0, done}, 32'd1);
    end else begin
      check("R2 remaining after start", {29'd0, remaining}, n);
      check("R2 busy after start", {31'd0, busy}, 32'd1);
    end
    for (int k = 0; k < n; k++) begin
      if (k == 1 && gap > 0) begin
        for (int g = 0; g < gap; g++) begin
          byte_valid = 1'b0;
          if (poke) begin
            start = 1'b1; disp_len = 2'd0; opnd_len = 2'd0;
          end
          @(negedge clk);
          start = 1'b0;
          check(poke ? "R10 start while busy" : "R3 gap holds count",
                {29'd0, remaining}, n - 1);
        end
      end
      byte_valid = 1'b1;
      byte_in = by[8*k +: 8];
      @(negedge clk);
      byte_valid = 1'b0;
      if (k < n - 1) begin
        check("R3 count down", {29'd0, remaining}, n - k - 1);
      end else begin
        check("R4 done on last byte", {31'd0, done}, 32'd1);
        check("R4 busy cleared", {31'd0, busy}, 32'd0);
        check("R4 remaining cleared", {29'd0, remaining}, 32'd0);
      end
    end
    @(negedge clk);
    check("R4 single pulse", {31'd0, done}, 32'd0);
    check("R11 result held", {disp, opnd}, last_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    check("R1 reset remaining", {29'd0, remaining}, 32'd0);
    check("R1 reset results", {disp, opnd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    xfer("R7 word operand",        2'd0, 2'd2, 1'b1, 1'b0, 32'h0000_1234 << 0 | 32'h0000_1234, 0, 1'b0);
    xfer("R6 byte disp negative",  2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0080, 0, 1'b0);
    xfer("R8 sext byte imm",       2'd2, 2'd1, 1'b1, 1'b0, 32'h0085_9234, 0, 1'b0);
    xfer("R8 port imm zero ext",   2'd0, 2'd1, 1'b1, 1'b1, 32'h0000_00F0, 0, 1'b0);
    xfer("R8 byte op zero ext",    2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_0090, 0, 1'b0);
    xfer("R9 far pointer",         2'd1, 2'd3, 1'b1, 1'b0, 32'h1234_5678, 2, 1'b0);
    xfer("R5 empty",               2'd0, 2'd0, 1'b1, 1'b0, 32'h0000_0000, 0, 1'b0);
    xfer("R6/R7 disp then operand",2'd1, 2'd2, 1'b1, 1'b0, 32'h00AB_CD7F, 3, 1'b1);
    xfer("R6 code three two bytes",2'd3, 2'd0, 1'b0, 1'b0, 32'h0000_8001, 1, 1'b1);

    // R10: bytes offered while idle must not disturb anything
    for (int i = 0; i < 3; i++) begin
      byte_valid = 1'b1;
      byte_in = 8'hC3 + 8'(i);
      @(negedge clk);
      check("R10 idle byte busy", {31'd0, busy}, 32'd0);
      check("R10 idle byte results", {disp, opnd}, last_exp);
    end
    byte_valid = 1'b0;
    @(negedge clk);

    xfer("R8 sext positive byte",  2'd0, 2'd1, 1'b1, 1'b0, 32'h0000_007E, 0, 1'b0);
    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule